// File: doc/BRIEF.md
# Two-Port Memory Bus Arbiter with Wait Escalation

This block decides, cycle by cycle, which of two masters owns a shared memory bus: a processor core port or a DMA port. Each port presents a request and a priority. A DMA request whose priority is strictly above the core's takes the bus at the core's next access boundary. A DMA request at or below the core's priority waits until the core stops requesting.

A programmable wait limit keeps the DMA from waiting forever. Once the DMA has waited that many cycles without a grant, it is marked escalated. The core then loses the bus on the next cycle, even in the middle of a nonvolatile-memory stall.

The core can start a stall burst whose length depends on the kind of memory operation. During the burst the core holds the bus whether or not it keeps requesting. The burst counter advances only while the core owns the bus. If the DMA preempts the core mid-burst, the burst is paused and resumes when the DMA releases the bus, so a stall always runs to completion.

Top module: `membus_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, `core_gnt`, `dma_gnt`, `dma_escalated` and `stall_active` are all 0.
- R2: `core_gnt` and `dma_gnt` are never high in the same cycle. Grants are registered and change one clock edge after the inputs that cause the change.
- R3: When neither port owns the bus, a sole requester is granted on the next cycle. When both ports request, the DMA is granted only if `dma_prio > core_prio` (unsigned); otherwise the core is granted, including on a tie.
- R4: While the core owns the bus and the DMA is not escalated, the DMA takes the bus in two cases. (a) If `dma_prio > core_prio`, it takes the bus on the first cycle in which `core_idle` is 1, no stall is in progress and no stall is being started. (b) At equal or lower priority, it takes the bus only once `core_req` is 0 and no stall is in progress or starting.
- R5: `dma_escalated` rises after `tmo_limit` consecutive clock edges at which `dma_req` is 1 and the DMA does not own the bus. On the following edge the DMA is granted, regardless of priority, `core_idle` or a stall in progress.
- R6: A `tmo_limit` of 0 never raises `dma_escalated`, however long the DMA waits.
- R7: The wait count restarts from zero whenever the DMA is granted or `dma_req` is 0, so waits that are broken up do not add together.
- R8: `dma_escalated` stays high while the escalated request persists. It returns to 0 on the edge after `dma_req` is seen low, and the programmed DMA priority applies again from then on.
- R9: A stall is started by `stall_go` = 1 while the core owns the bus and no stall is running. The burst lasts `stall_kind` 0 = 11, 1 = 8, 2 = 3, or 3 = 127 core-owned cycles, and `stall_active` is high for exactly those cycles when the core is not preempted.
- R10: The stall counter advances only in cycles where the core owns the bus and is frozen while the DMA owns it. When the DMA releases the bus with a stall pending, the core is granted on the next edge and the stall finishes with the full length counted in core-owned cycles.
- R11: The core keeps the bus during a stall even if `core_req` falls or a higher-priority DMA requests with `core_idle` high. Only escalation can take the bus from it.
- R12: The DMA keeps its grant while `dma_req` is 1. When `dma_req` falls, the bus goes to the core if `core_req` is 1 or a stall is pending, and otherwise to no one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Core requests the bus |
| core_idle | input | 1 | Core is at an access boundary and may be preempted |
| core_prio | input | PRIO_W | Core access priority |
| stall_go | input | 1 | Start a stall burst (honoured only while the core owns the bus and no stall is running) |
| stall_kind | input | 2 | Stall length select: 0 = byte, 1 = word, 2 = block word, 3 = block erase |
| dma_req | input | 1 | DMA requests the bus |
| dma_prio | input | PRIO_W | Programmed DMA priority |
| tmo_limit | input | TMO_W | Wait cycles before escalation; 0 disables escalation |
| core_gnt | output | 1 | Core owns the bus |
| dma_gnt | output | 1 | DMA owns the bus |
| dma_escalated | output | 1 | DMA priority is currently raised by a timeout |
| stall_active | output | 1 | A stall burst is in progress (running or paused) |

## Verification
The assertions assume the requests are held stable from one clock edge to the next, and that `stall_go` is raised only together with `core_req`. They also assume the priorities and the wait limit do not change in the middle of a wait the checks rely on. The stimulus changes every input only on the falling clock edge, and sets priorities and the limit between scenarios while both requests are low. `stall_go` is pulsed for one cycle while the core holds the bus and `core_req` is high. The bench compares all four outputs against a behavioural model on every cycle, so paused and resumed stalls, broken-up waits and ties are all checked at the ports.

// File: rtl/membus_arb_pkg.sv
// Shared types for the two-port memory bus arbiter.
// Assumes: used only by the membus_arbiter hierarchy.
package membus_arb_pkg;

    // Current bus owner
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CORE = 2'd1,
        OWN_DMA  = 2'd2
    } owner_e;

    // Kind of nonvolatile-memory stall burst
    typedef enum logic [1:0] {
        SK_BYTE     = 2'd0,
        SK_WORD     = 2'd1,
        SK_BLKWORD  = 2'd2,
        SK_BLKERASE = 2'd3
    } stall_kind_e;

endpackage

// File: rtl/membus_arb_stall.sv
// Stall burst sequencer: loads a length chosen by the stall kind and
// counts it down only in cycles where the core owns the bus.
// Assumes: go is honoured only while the core owns the bus and no
// burst is running; a paused burst resumes where it stopped.
module membus_arb_stall
    import membus_arb_pkg::*;
#(
    parameter int LEN_BYTE     = 11,
    parameter int LEN_WORD     = 8,
    parameter int LEN_BLKWORD  = 3,
    parameter int LEN_BLKERASE = 127
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       core_owned,
    input  logic       go,
    input  logic [1:0] kind,
    output logic       active,
    output logic       starting
);
    localparam int MAX_AB  = (LEN_BYTE > LEN_WORD) ? LEN_BYTE : LEN_WORD;
    localparam int MAX_CD  = (LEN_BLKWORD > LEN_BLKERASE) ? LEN_BLKWORD : LEN_BLKERASE;
    localparam int MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_sel;

    // Pick the burst length for the requested kind
    always_comb begin
        unique case (stall_kind_e'(kind))
            SK_BYTE:     len_sel = CNT_W'(LEN_BYTE);
            SK_WORD:     len_sel = CNT_W'(LEN_WORD);
            SK_BLKWORD:  len_sel = CNT_W'(LEN_BLKWORD);
            default:     len_sel = CNT_W'(LEN_BLKERASE);
        endcase
    end

    assign active   = (cnt_q != '0);
    assign starting = core_owned && go && !active;

    // Load on a start, count down only while the core holds the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (starting) begin
            cnt_q <= len_sel;
        end else if (core_owned && active) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // A burst in progress does not move while the DMA holds the bus
    p_stall_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !core_owned) |=> $stable(cnt_q));

    // A running burst shortens by exactly one per core-owned cycle
    p_stall_counts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && core_owned) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/membus_arb_timeout.sv
// Wait timer: counts consecutive cycles in which the DMA requests but
// does not own the bus, and raises an escalation flag at the limit.
// Assumes: limit 0 disables escalation; the flag lasts until the DMA
// drops its request.
module membus_arb_timeout #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_req,
    input  logic             dma_owned,
    input  logic [TMO_W-1:0] limit,
    output logic             escalated
);
    localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

    logic [TMO_W-1:0] wait_q;
    logic             esc_q;
    logic             waiting;
    logic             esc_d;
    logic             reached;

    assign waiting   = dma_req && !dma_owned;
    assign reached   = ({1'b0, wait_q} + 1'b1) >= {1'b0, limit};
    assign esc_d     = dma_req && (esc_q || (waiting && (limit != '0) && reached));
    assign escalated = esc_q;

    // Track the escalation flag for the current request
    always_ff @(posedge clk) begin
        if (!rst_n) esc_q <= 1'b0;
        else        esc_q <= esc_d;
    end

    // Count the current uninterrupted wait, saturating at the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (!waiting || esc_d) begin
            wait_q <= '0;
        end else if (wait_q != CNT_MAX) begin
            wait_q <= wait_q + 1'b1;
        end
    end

    // With the limit at zero the flag cannot rise
    p_zero_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!esc_q && limit == '0) |=> !esc_q);

    // Dropping the request ends escalation on the next edge
    p_esc_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_req |=> !esc_q);

    // A granted or absent request restarts the wait from zero
    p_wait_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !waiting |=> (wait_q == '0));

endmodule

// File: rtl/membus_arb_owner.sv
// Ownership state machine: chooses the bus owner for the next cycle
// from requests, priorities, the core boundary, stall status and the
// escalation flag, and drives the two registered grants.
// Assumes: an escalated DMA preempts unconditionally; otherwise the
// owner changes only at a core boundary or when a port stops requesting.
module membus_arb_owner
    import membus_arb_pkg::*;
#(
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_idle,
    input  logic [PRIO_W-1:0] core_prio,
    input  logic              dma_req,
    input  logic [PRIO_W-1:0] dma_prio,
    input  logic              escalated,
    input  logic              stall_running,
    input  logic              stall_starting,
    output logic              core_gnt,
    output logic              dma_gnt
);
    owner_e own_q, own_d;
    logic   dma_higher;
    logic   stall_busy;

    assign dma_higher = dma_prio > core_prio;
    assign stall_busy = stall_running || stall_starting;

    // Decide the next owner
    always_comb begin
        own_d = own_q;
        unique case (own_q)
            OWN_NONE: begin
                if (dma_req && (!core_req || escalated || dma_higher)) own_d = OWN_DMA;
                else if (core_req)                                     own_d = OWN_CORE;
                else                                                   own_d = OWN_NONE;
            end
            OWN_CORE: begin
                if (dma_req && escalated)
                    own_d = OWN_DMA;
                else if (!core_req && !stall_busy)
                    own_d = dma_req ? OWN_DMA : OWN_NONE;
                else if (dma_req && dma_higher && core_idle && !stall_busy)
                    own_d = OWN_DMA;
                else
                    own_d = OWN_CORE;
            end
            OWN_DMA: begin
                if (!dma_req) own_d = (core_req || stall_running) ? OWN_CORE : OWN_NONE;
                else          own_d = OWN_DMA;
            end
            default: own_d = OWN_NONE;
        endcase
    end

    // Register the owner
    always_ff @(posedge clk) begin
        if (!rst_n) own_q <= OWN_NONE;
        else        own_q <= own_d;
    end

    assign core_gnt = (own_q == OWN_CORE);
    assign dma_gnt  = (own_q == OWN_DMA);

    // Never two owners
    p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_gnt, dma_gnt}));

    // An escalated waiting DMA takes the bus from the core next cycle
    p_esc_preempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_gnt && dma_req && escalated) |=> dma_gnt);

    // A non-escalated DMA at or below core priority never cuts in
    p_low_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_gnt && core_req && !escalated && !dma_higher) |=> !dma_gnt);

    // A requesting DMA keeps the bus
    p_dma_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gnt && dma_req) |=> dma_gnt);

    // A pending stall gets the bus back when the DMA lets go
    p_stall_returns_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gnt && !dma_req && stall_running) |=> core_gnt);

    // The core is not removed mid-stall except by escalation
    p_stall_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (core_gnt && stall_running && !escalated) |=> core_gnt);

endmodule

// File: rtl/membus_arbiter.sv
// Top of the two-port memory bus arbiter: core port versus DMA port,
// with a DMA wait timer that escalates and a pausable core stall burst.
// Assumes: all inputs synchronous to clk; stall_go comes with core_req.
module membus_arbiter #(
    parameter int PRIO_W       = 3,
    parameter int TMO_W        = 8,
    parameter int LEN_BYTE     = 11,
    parameter int LEN_WORD     = 8,
    parameter int LEN_BLKWORD  = 3,
    parameter int LEN_BLKERASE = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_idle,
    input  logic [PRIO_W-1:0] core_prio,
    input  logic              stall_go,
    input  logic [1:0]        stall_kind,
    input  logic              dma_req,
    input  logic [PRIO_W-1:0] dma_prio,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              core_gnt,
    output logic              dma_gnt,
    output logic              dma_escalated,
    output logic              stall_active
);
    logic esc;
    logic st_run;
    logic st_start;

    membus_arb_timeout #(.TMO_W(TMO_W)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_req   (dma_req),
        .dma_owned (dma_gnt),
        .limit     (tmo_limit),
        .escalated (esc)
    );

    membus_arb_stall #(
        .LEN_BYTE     (LEN_BYTE),
        .LEN_WORD     (LEN_WORD),
        .LEN_BLKWORD  (LEN_BLKWORD),
        .LEN_BLKERASE (LEN_BLKERASE)
    ) u_stall (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_owned (core_gnt),
        .go         (stall_go),
        .kind       (stall_kind),
        .active     (st_run),
        .starting   (st_start)
    );

    membus_arb_owner #(.PRIO_W(PRIO_W)) u_own (
        .clk            (clk),
        .rst_n          (rst_n),
        .core_req       (core_req),
        .core_idle      (core_idle),
        .core_prio      (core_prio),
        .dma_req        (dma_req),
        .dma_prio       (dma_prio),
        .escalated      (esc),
        .stall_running  (st_run),
        .stall_starting (st_start),
        .core_gnt       (core_gnt),
        .dma_gnt        (dma_gnt)
    );

    assign dma_escalated = esc;
    assign stall_active  = st_run;

    // Reset leaves every output low on the first cycle afterwards
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!core_gnt && !dma_gnt && !dma_escalated && !stall_active));

endmodule

// File: tb/sim_membus_arbiter.sv
module sim_membus_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_req = 0, core_idle = 0, stall_go = 0, dma_req = 0;
    logic [2:0] core_prio = 0, dma_prio = 0;
    logic [1:0] stall_kind = 0;
    logic [7:0] tmo_limit = 0;
    logic       core_gnt, dma_gnt, dma_escalated, stall_active;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    membus_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_idle(core_idle),
        .core_prio(core_prio), .stall_go(stall_go), .stall_kind(stall_kind),
        .dma_req(dma_req), .dma_prio(dma_prio), .tmo_limit(tmo_limit),
        .core_gnt(core_gnt), .dma_gnt(dma_gnt), .dma_escalated(dma_escalated),
        .stall_active(stall_active)
    );

    // Behavioural reference model: 0 none, 1 core, 2 dma
    int m_own = 0, m_wait = 0, m_stall = 0;
    bit m_esc = 0;

    function automatic int stall_len(input int k);
        case (k)
            0: return 11;
            1: return 8;
            2: return 3;
            default: return 127;
        endcase
    endfunction

    always @(posedge clk) begin
        int  n_own, n_wait, n_stall;
        bit  n_esc, waiting, busy, starting, hi;
        if (!rst_n) begin
            m_own = 0; m_wait = 0; m_stall = 0; m_esc = 0;
        end else begin
            waiting  = dma_req && (m_own != 2);
            starting = (m_own == 1) && stall_go && (m_stall == 0);
            busy     = (m_stall != 0) || starting;
            hi       = dma_prio > core_prio;
            n_esc    = dma_req && (m_esc || (waiting && tmo_limit != 0 && m_wait + 1 >= tmo_limit));
            n_wait   = (waiting && !n_esc) ? ((m_wait < 255) ? m_wait + 1 : 255) : 0;
            n_own    = m_own;
            if (m_own == 0) begin
                if (dma_req && (!core_req || m_esc || hi)) n_own = 2;
                else if (core_req) n_own = 1;
            end else if (m_own == 1) begin
                if (dma_req && m_esc) n_own = 2;
                else if (!core_req && !busy) n_own = dma_req ? 2 : 0;
                else if (dma_req && hi && core_idle && !busy) n_own = 2;
            end else begin
                if (!dma_req) n_own = (core_req || m_stall != 0) ? 1 : 0;
            end
            n_stall = m_stall;
            if (starting) n_stall = stall_len(stall_kind);
            else if (m_own == 1 && m_stall != 0) n_stall = m_stall - 1;
            m_own = n_own; m_wait = n_wait; m_esc = n_esc; m_stall = n_stall;
        end
    end

    // Compare every cycle against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (core_gnt !== (m_own == 1) || dma_gnt !== (m_own == 2) ||
                dma_escalated !== m_esc || stall_active !== (m_stall != 0)) begin
                fails++;
                $display("FAIL %s model: got cg=%b dg=%b esc=%b st=%b exp cg=%b dg=%b esc=%b st=%b",
                         tag, core_gnt, dma_gnt, dma_escalated, stall_active,
                         m_own == 1, m_own == 2, m_esc, m_stall != 0);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string rq, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int k, n;
        bit seen;
        step(3);
        // R1: quiet during and after reset
        check("R1", {core_gnt, dma_gnt, dma_escalated, stall_active} == 4'b0, core_gnt + dma_gnt, 0);
        rst_n = 1;
        step(1);
        check("R1", {core_gnt, dma_gnt, dma_escalated, stall_active} == 4'b0, dma_escalated, 0);

        // R3: sole requesters and priority ties
        tag = "R3";
        core_req = 1; step(2);
        check("R3", core_gnt, core_gnt, 1);
        core_req = 0; step(2);
        dma_req = 1; step(2);
        check("R3", dma_gnt, dma_gnt, 1);
        dma_req = 0; step(2);
        core_prio = 3; dma_prio = 1; core_req = 1; dma_req = 1; step(2);
        check("R3", core_gnt, core_gnt, 1);
        core_req = 0; dma_req = 0; step(2);
        dma_prio = 5; core_req = 1; dma_req = 1; step(2);
        check("R3", dma_gnt, dma_gnt, 1);
        core_req = 0; dma_req = 0; step(2);
        dma_prio = 3; core_req = 1; dma_req = 1; step(2);
        check("R3", core_gnt, core_gnt, 1);
        core_req = 0; dma_req = 0; step(2);

        // R4: higher DMA waits for a core boundary
        tag = "R4";
        core_req = 1; core_idle = 0; step(2);
        dma_prio = 5; dma_req = 1; step(4);
        check("R4", !dma_gnt, dma_gnt, 0);
        core_idle = 1; step(1);
        check("R4", dma_gnt, dma_gnt, 1);
        // R12: release hands the bus back to a requesting core
        tag = "R12";
        step(3);
        check("R12", dma_gnt, dma_gnt, 1);
        dma_req = 0; step(1);
        check("R12", core_gnt, core_gnt, 1);
        // R4: lower DMA waits for core to stop requesting
        tag = "R4";
        dma_prio = 1; dma_req = 1; step(5);
        check("R4", core_gnt, core_gnt, 1);
        core_req = 0; step(1);
        check("R4", dma_gnt, dma_gnt, 1);
        dma_req = 0; step(1);
        check("R12", !core_gnt && !dma_gnt, core_gnt + dma_gnt, 0);

        // R5: escalation after the limit, then forced grant
        tag = "R5";
        tmo_limit = 6; core_req = 1; core_idle = 0; step(2);
        dma_req = 1; k = 0;
        for (int i = 0; i < 20; i++) begin
            step(1); k++;
            if (dma_escalated) break;
        end
        check("R5", k == 6, k, 6);
        step(1);
        check("R5", dma_gnt, dma_gnt, 1);
        // R8: flag clears after withdrawal
        tag = "R8";
        step(3);
        dma_req = 0; step(1);
        check("R8", !dma_escalated && core_gnt, dma_escalated, 0);

        // R6: zero limit never escalates
        tag = "R6";
        tmo_limit = 0; dma_req = 1; seen = 0;
        for (int i = 0; i < 300; i++) begin
            step(1);
            if (dma_escalated || dma_gnt) seen = 1;
        end
        check("R6", !seen, seen, 0);
        dma_req = 0; step(1);

        // R7: broken-up waits do not add together
        tag = "R7";
        tmo_limit = 5; seen = 0;
        for (int r = 0; r < 4; r++) begin
            dma_req = 1;
            for (int i = 0; i < 4; i++) begin step(1); if (dma_escalated) seen = 1; end
            dma_req = 0; step(1);
        end
        check("R7", !seen, seen, 0);

        // R9: each stall length, core idle and no DMA
        tag = "R9";
        core_idle = 1;
        for (int kd = 0; kd < 4; kd++) begin
            stall_kind = 2'(kd); stall_go = 1; step(1); stall_go = 0;
            n = 0;
            for (int i = 0; i < 300 && stall_active; i++) begin n++; step(1); end
            check("R9", n == stall_len(kd), n, stall_len(kd));
        end

        // R11 and R10: block-erase stall, core drops request, DMA escalates mid-stall
        tag = "R11";
        tmo_limit = 10; dma_prio = 7; stall_kind = 3;
        stall_go = 1; step(1); stall_go = 0; core_req = 0;
        n = 1; // cycle just sampled was core-owned with the stall running
        dma_req = 1;
        for (int i = 0; i < 5; i++) begin step(1); if (core_gnt && stall_active) n++; end
        check("R11", core_gnt, core_gnt, 1);
        tag = "R10";
        k = 0;
        for (int i = 0; i < 1000 && stall_active; i++) begin
            step(1);
            if (dma_gnt) k++;
            if (k == 20) dma_req = 0;
            if (core_gnt && stall_active) n++;
        end
        check("R10", n == 127, n, 127);
        check("R10", k >= 20, k, 20);
        step(1);
        check("R10", !core_gnt && !dma_gnt, core_gnt, 0);

        step(3);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule